// File: doc/BRIEF.md
# Two-Player Dice Turn and Game-Over Controller

This block sequences a two-player dice game. Each player owns one throw button. A single turn bit decides whose button counts. When the player holding the turn presses, the block emits a one-clock strobe that tells the dice and score logic to commit a throw. The same edge passes the turn to the opponent. A second output tells the score logic which player's total to update.

The block watches the tens digit of both scores. Once a configurable threshold bit of either digit is set, the game freezes: the turn no longer changes and no further throw is accepted. The winner's LED and buzzer enable then light. A game reset brings everything back to the opening state and asks the score logic to clear both totals. Debouncing, the dice counter, score arithmetic and display decoding live outside this block.

Top module: `dice_turn_ctrl`

## Requirements
- R1: After reset, player A holds the turn. `ledTurnAO`=1, `ledTurnBO`=0, `gameOverO`=0, and every winner, buzzer and strobe output is 0. Exactly one turn LED is lit at all times.
- R2: A press by the player holding the turn yields exactly one `throwStbO` pulse, one clock wide. With 2 synchroniser stages, the pulse is high after the third rising clock edge following the press. `throwerBO` is 0 for player A and 1 for player B during the pulse.
- R3: A press by the player not holding the turn produces no strobe and leaves the turn unchanged.
- R4: Each accepted throw hands the turn to the other player, so accepted throws strictly alternate between A and B.
- R5: A button held down for many cycles counts as a single press. A new throw needs a release first.
- R6: If both buttons rise in the same cycle, only the press of the player holding the turn is accepted.
- R7: `gameOverO` rises one clock after bit 1 of either tens-digit input becomes set, for example a tens digit of 3. A tens digit of 1 does not end the game.
- R8: Once the game is over, no press produces a strobe and the turn does not change.
- R9: The winner LED and buzzer enable of the player whose tens-digit threshold bit is set go high together with `gameOverO`. The other player's LED and buzzer stay low.
- R10: The game reset input, sampled on a clock edge, returns the turn to A and clears the game-over and winner outputs. During every cycle it is held, `scoreClrO` is 1 one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| gameRstI | input | 1 | Synchronous game restart |
| btnAI | input | 1 | Throw button, player A (debounced, asynchronous) |
| btnBI | input | 1 | Throw button, player B (debounced, asynchronous) |
| tensAI | input | 4 | Tens digit of player A's score |
| tensBI | input | 4 | Tens digit of player B's score |
| throwStbO | output | 1 | One-cycle strobe: commit dice value and score |
| throwerBO | output | 1 | Player of the accepted throw (0 = A, 1 = B) |
| scoreClrO | output | 1 | Request to clear both scores |
| ledTurnAO | output | 1 | Player A holds the turn |
| ledTurnBO | output | 1 | Player B holds the turn |
| gameOverO | output | 1 | Game has ended |
| winLedAO | output | 1 | Player A winner light |
| winLedBO | output | 1 | Player B winner light |
| buzzAO | output | 1 | Player A buzzer enable |
| buzzBO | output | 1 | Player B buzzer enable |

## Verification
A corrupted turn bit shows up at once on the turn LEDs. It also shows up as `throwerBO` at the next strobe, where the wrong player's press is honoured or the right one is dropped. A broken edge detector shows as extra strobes within a cycle of a held press. A stuck or missing game-over flag shows one clock after the tens digit crosses the threshold: either on the winner and buzzer outputs, or as a strobe that should have been suppressed. The bench therefore counts strobes over whole hold windows and reads the turn LEDs after each attempt.

// File: rtl/dice_turn_pkg.sv
package dice_turn_pkg;
  typedef struct packed {
    logic accept;  // commit a throw and pass the turn
    logic clear;   // restart the game
  } ctlStb_t;
endpackage

// File: rtl/dice_turn_ctl.sv
module dice_turn_ctl
  import dice_turn_pkg::*;
(
  input  logic       gameRstI,
  input  logic [1:0] riseI,     // [0] player A, [1] player B
  input  logic       turnBI,
  input  logic       blockedI,
  output ctlStb_t    stbO
);
  logic ownRise;

  // Only the turn holder's edge is considered (R3, R6)
  assign ownRise = turnBI ? riseI[1] : riseI[0];

  always_comb begin
    stbO.clear  = gameRstI;
    stbO.accept = ownRise && !blockedI && !gameRstI;
  end
endmodule

// File: rtl/dice_turn_dp.sv
module dice_turn_dp
  import dice_turn_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int TENS_W      = 4,
  parameter logic [TENS_W-1:0] OVER_MASK = TENS_W'(2)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        btnI,
  input  logic [TENS_W-1:0] tensAI,
  input  logic [TENS_W-1:0] tensBI,
  input  ctlStb_t           stbI,
  output logic [1:0]        riseO,
  output logic              turnBO,
  output logic              blockedO,
  output logic              throwStbO,
  output logic              throwerBO,
  output logic              scoreClrO,
  output logic              overO,
  output logic [1:0]        winO
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [1:0] hit;
  logic [1:0] prevQ;
  logic       turnQ, overQ, stbQ, throwerQ, clrQ;
  logic [1:0] winQ;
  logic [1:0] synced;

  assign hit[0] = |(tensAI & OVER_MASK);
  assign hit[1] = |(tensBI & OVER_MASK);

  for (genvar p = 0; p < 2; p++) begin : g_player
    logic [SYNC_STAGES-1:0] chainQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        chainQ   <= '0;
        prevQ[p] <= 1'b0;
      end else begin
        chainQ   <= {chainQ[SYNC_STAGES-2:0], btnI[p]};
        prevQ[p] <= chainQ[LAST];
      end
    end
    assign synced[p] = chainQ[LAST];
    assign riseO[p]  = synced[p] && !prevQ[p];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      turnQ    <= 1'b0;
      overQ    <= 1'b0;
      winQ     <= '0;
      stbQ     <= 1'b0;
      throwerQ <= 1'b0;
      clrQ     <= 1'b0;
    end else begin
      clrQ <= stbI.clear;
      stbQ <= stbI.accept;
      if (stbI.clear) begin
        turnQ <= 1'b0;
        overQ <= 1'b0;
        winQ  <= '0;
      end else begin
        overQ <= overQ | (|hit);
        winQ  <= winQ | hit;
        if (stbI.accept) begin
          throwerQ <= turnQ;
          turnQ    <= !turnQ;
        end
      end
    end
  end

  assign turnBO    = turnQ;
  assign blockedO  = overQ || (|hit);
  assign throwStbO = stbQ;
  assign throwerBO = throwerQ;
  assign scoreClrO = clrQ;
  assign overO     = overQ;
  assign winO      = winQ;

  p_stb_one_cycle_r2: assert property (@(posedge clk) disable iff (!rstN)
    stbQ |=> !stbQ);
  p_turn_flips_r4: assert property (@(posedge clk) disable iff (!rstN)
    stbQ |-> (turnQ != $past(turnQ)));
  p_no_throw_after_over_r8: assert property (@(posedge clk) disable iff (!rstN)
    overQ |=> !stbQ);
  p_turn_frozen_r8: assert property (@(posedge clk) disable iff (!rstN)
    (overQ && !stbI.clear) |=> $stable(turnQ));
  p_winner_implies_over_r9: assert property (@(posedge clk) disable iff (!rstN)
    (|winQ) |-> overQ);
  p_clear_follows_r10: assert property (@(posedge clk) disable iff (!rstN)
    stbI.clear |=> (clrQ && !turnQ && !overQ));
endmodule

// File: rtl/dice_turn_ctrl.sv
module dice_turn_ctrl
  import dice_turn_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int TENS_W      = 4,
  parameter logic [TENS_W-1:0] OVER_MASK = TENS_W'(2)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              gameRstI,
  input  logic              btnAI,
  input  logic              btnBI,
  input  logic [TENS_W-1:0] tensAI,
  input  logic [TENS_W-1:0] tensBI,
  output logic              throwStbO,
  output logic              throwerBO,
  output logic              scoreClrO,
  output logic              ledTurnAO,
  output logic              ledTurnBO,
  output logic              gameOverO,
  output logic              winLedAO,
  output logic              winLedBO,
  output logic              buzzAO,
  output logic              buzzBO
);
  ctlStb_t    stb;
  logic [1:0] rise;
  logic [1:0] win;
  logic       turnB, blocked;

  dice_turn_ctl ctl_i (
    .gameRstI (gameRstI),
    .riseI    (rise),
    .turnBI   (turnB),
    .blockedI (blocked),
    .stbO     (stb)
  );

  dice_turn_dp #(
    .SYNC_STAGES (SYNC_STAGES),
    .TENS_W      (TENS_W),
    .OVER_MASK   (OVER_MASK)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .btnI      ({btnBI, btnAI}),
    .tensAI    (tensAI),
    .tensBI    (tensBI),
    .stbI      (stb),
    .riseO     (rise),
    .turnBO    (turnB),
    .blockedO  (blocked),
    .throwStbO (throwStbO),
    .throwerBO (throwerBO),
    .scoreClrO (scoreClrO),
    .overO     (gameOverO),
    .winO      (win)
  );

  assign ledTurnAO = !turnB;
  assign ledTurnBO = turnB;
  assign winLedAO  = win[0];
  assign winLedBO  = win[1];
  assign buzzAO    = win[0];
  assign buzzBO    = win[1];

  p_turn_led_one_r1: assert property (@(posedge clk) disable iff (!rstN)
    $countones({ledTurnAO, ledTurnBO}) == 1);
endmodule

// File: tb/dice_turn_ctrl_tb.sv
module dice_turn_ctrl_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic gameRst = 1'b0;
  logic btnA = 1'b0, btnB = 1'b0;
  logic [3:0] tensA = '0, tensB = '0;
  logic throwStb, throwerB, scoreClr, ledA, ledB, over, winA, winB, bzA, bzB;

  int tests = 0;
  int fails = 0;
  int pulseCnt = 0;
  logic lastThrower = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dice_turn_ctrl dut_i (
    .clk(clk), .rstN(rstN), .gameRstI(gameRst), .btnAI(btnA), .btnBI(btnB),
    .tensAI(tensA), .tensBI(tensB), .throwStbO(throwStb), .throwerBO(throwerB),
    .scoreClrO(scoreClr), .ledTurnAO(ledA), .ledTurnBO(ledB), .gameOverO(over),
    .winLedAO(winA), .winLedBO(winB), .buzzAO(bzA), .buzzBO(bzB)
  );

  always @(posedge clk) if (throwStb) begin
    pulseCnt++;
    lastThrower = throwerB;
  end

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // {btnA, btnB, expected pulses, expected thrower, expected turnB after}
  localparam logic [4:0] VEC [6] = '{
    5'b10_1_0_1,  // A holds turn, A presses: accepted (R2 R4)
    5'b10_0_0_1,  // B holds turn, A presses: ignored (R3)
    5'b01_1_1_0,  // B presses: accepted, back to A (R4)
    5'b11_1_0_1,  // both press, A holds: only A (R6)
    5'b11_1_1_0,  // both press, B holds: only B (R6)
    5'b01_0_0_0   // A holds, B presses: ignored (R3)
  };

  initial begin
    #3_000_000;
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    cyc(3);
    // R1 reset state
    chk("R1 ledTurnA", ledA, 1); chk("R1 ledTurnB", ledB, 0);
    chk("R1 gameOver", over, 0); chk("R1 winners", {winA, winB, bzA, bzB}, 0);
    chk("R1 strobe", throwStb, 0);
    rstN = 1'b1;
    cyc(2);

    // Vector walk: each press held 8 cycles to exercise R5
    foreach (VEC[k]) begin
      pulseCnt = 0;
      btnA = VEC[k][4]; btnB = VEC[k][3];
      cyc(8);
      btnA = 1'b0; btnB = 1'b0;
      cyc(4);
      chk($sformatf("R5 vec%0d pulses", k), pulseCnt, int'(VEC[k][2]));
      if (VEC[k][2]) chk($sformatf("R2 vec%0d thrower", k), lastThrower, int'(VEC[k][1]));
      chk($sformatf("R4 vec%0d turnB", k), ledB, int'(VEC[k][0]));
      chk($sformatf("R1 vec%0d turnA led", k), ledA, int'(!VEC[k][0]));
    end

    // R2 exact timing: A holds the turn here
    btnA = 1'b1;
    cyc(2); chk("R2 no strobe after 2 edges", throwStb, 0);
    cyc(1); chk("R2 strobe after 3 edges", throwStb, 1);
    chk("R2 thrower A", throwerB, 0);
    cyc(1); chk("R2 strobe one wide", throwStb, 0);
    btnA = 1'b0; cyc(4);
    chk("R4 turn now B", ledB, 1);

    // R7: tens digit 1 does not end the game
    tensA = 4'd1; cyc(2);
    chk("R7 tens 1 no over", over, 0);
    // R7 R9: B reaches 30
    tensB = 4'd3; cyc(1);
    chk("R7 over one clock later", over, 1);
    chk("R9 winB", winB, 1); chk("R9 buzzB", bzB, 1);
    chk("R9 winA low", winA, 0); chk("R9 buzzA low", bzA, 0);
    // R8: B holds the turn but is frozen
    pulseCnt = 0;
    btnB = 1'b1; cyc(6); btnB = 1'b0; cyc(4);
    chk("R8 no strobe after over", pulseCnt, 0);
    chk("R8 turn frozen on B", ledB, 1);

    // R10 game reset
    gameRst = 1'b1; cyc(1);
    chk("R10 scoreClr", scoreClr, 1); chk("R10 over cleared", over, 0);
    chk("R10 turn A", ledA, 1); chk("R10 winB cleared", winB, 0);
    cyc(1); chk("R10 scoreClr held", scoreClr, 1);
    gameRst = 1'b0; tensA = '0; tensB = '0;
    cyc(1); chk("R10 scoreClr drops", scoreClr, 0);
    cyc(1); chk("R10 over stays low", over, 0);

    // R9 other player: A wins with digit 2 pattern bit set
    tensA = 4'd3; cyc(1);
    chk("R9 winA", winA, 1); chk("R9 winB low", winB, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule